// File: doc/BRIEF.md
# Sleep-Mode Entry and Wake Controller

This block governs the low-power nap of a synchronous memory interface. A sleep request arrives on an asynchronous, active-high pin. The controller brings it into the clock domain through a short flop chain and then walks a four-state machine: NORMAL, ENTERING, SLEEP and WAKING. The entry and wake latencies are counted in clock cycles from the synchronized edge of the request.

While the block is asleep, the memory core counts as deselected. Every incoming command is replaced by a deselect, the input-disable line is raised, and the output-enable gate forces the data drivers to high impedance. The block keeps no state of its own that sleep could disturb. The array and its configuration sit beside it and remain untouched.

After the pin drops, a short recovery window follows. In that window only deselect and read commands reach the core. Any other command is turned into a deselect and reported on a single-cycle violation flag. A request that is withdrawn before the entry countdown ends returns the block straight to NORMAL.

Top module: `nap_ctrl`

## Requirements
- R1: While reset is held and right after it, `state_o` is NORMAL (code 0), `in_dis` is 0 and `rec_viol` is 0.
- R2: The pin passes two synchronizer flops. On the third rising edge after the pin goes high, `state_o` is ENTERING (code 1). On the fourth, it is SLEEP (code 2).
- R3: If the synchronized request falls while the block is ENTERING, the next state is NORMAL and SLEEP is never reached. A one-cycle pin pulse shows ENTERING for one cycle and then NORMAL.
- R4: In SLEEP, `cmd_out` is deselect (code 0) whatever `cmd_in` carries, and `in_dis` is 1. Outside SLEEP, `in_dis` is 0.
- R5: `oe_gated` is 0 in SLEEP and equals `oe_req` in every other state.
- R6: On the third rising edge after the pin goes low in SLEEP, `state_o` is WAKING (code 3). On the fourth, it is NORMAL.
- R7: In WAKING, deselect (code 0) and read (code 1) pass to `cmd_out` unchanged.
- R8: In WAKING, write (code 2) and burst-continue (code 3) leave as deselect. `rec_viol` is 1 for exactly the cycle after each such blocked command and 0 otherwise.
- R9: In NORMAL and ENTERING, `cmd_out` equals `cmd_in` for every code.
- R10: A request that reappears during WAKING does not cut the wake short. The block reaches NORMAL first and enters ENTERING one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| sleep_pin | input | 1 | Asynchronous active-high sleep request |
| cmd_in | input | 2 | Command code: 0 deselect, 1 read, 2 write, 3 burst-continue |
| oe_req | input | 1 | Output enable requested by the memory datapath |
| cmd_out | output | 2 | Filtered command presented to the memory core |
| oe_gated | output | 1 | Output enable after the sleep gate; 0 tri-states the data outputs |
| in_dis | output | 1 | High while inputs other than the sleep pin are ignored |
| rec_viol | output | 1 | Pulses for one cycle after a command is blocked during recovery |
| state_o | output | 2 | Controller state: 0 NORMAL, 1 ENTERING, 2 SLEEP, 3 WAKING |

## Verification
The assertions assume that `rst_n` is the only asynchronous control besides the sleep pin. They also assume that `cmd_in` and `oe_req` are stable around the rising edge. The sleep pin itself may change at any time, because nothing outside the synchronizer samples it. The stimulus changes every input only on the falling edge and flips the pin on about one cycle in ten. That rate produces short pulses that abort entry, requests that reappear while waking, and every command code inside the recovery window. A cycle model in the bench predicts the state, the filtered command, the gate and the flag for every cycle.

// File: rtl/nap_pkg.sv
`timescale 1ns/1ps
package nap_pkg;
  localparam int CMD_W = 2;

  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_ENTER  = 2'd1,
    ST_SLEEP  = 2'd2,
    ST_WAKE   = 2'd3
  } nap_state_e;

  localparam logic [CMD_W-1:0] CMD_DESEL = 2'd0;
  localparam logic [CMD_W-1:0] CMD_READ  = 2'd1;
  localparam logic [CMD_W-1:0] CMD_WRITE = 2'd2;
  localparam logic [CMD_W-1:0] CMD_CONT  = 2'd3;
endpackage

// File: rtl/nap_sync.sv
`timescale 1ns/1ps
module nap_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= RST_VAL;
        else        sh_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= {sh_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/nap_fsm.sv
`timescale 1ns/1ps
module nap_fsm import nap_pkg::*; #(
  parameter int ENTRY_CYC = 2,
  parameter int WAKE_CYC  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  output nap_state_e state
);
  localparam int MAXC  = (ENTRY_CYC > WAKE_CYC) ? ENTRY_CYC : WAKE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] ENTER_LAST = CNT_W'(ENTRY_CYC - 1);
  localparam logic [CNT_W-1:0] WAKE_LAST  = CNT_W'(WAKE_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

  nap_state_e       st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             adv;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    unique case (st_q)
      ST_NORMAL: begin
        if (req) begin
          st_n  = ST_ENTER;
          cnt_n = CNT_ONE;
        end
      end
      ST_ENTER: begin
        if (!req) begin
          st_n  = ST_NORMAL;
          cnt_n = '0;
        end else if (cnt_q >= ENTER_LAST) begin
          st_n  = ST_SLEEP;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q + CNT_ONE;
        end
      end
      ST_SLEEP: begin
        if (!req) begin
          st_n  = ST_WAKE;
          cnt_n = CNT_ONE;
        end
      end
      ST_WAKE: begin
        if (cnt_q >= WAKE_LAST) begin
          st_n  = ST_NORMAL;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q + CNT_ONE;
        end
      end
      default: begin
        st_n  = ST_NORMAL;
        cnt_n = '0;
      end
    endcase
  end

  assign adv = (st_q != ST_NORMAL) || req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_NORMAL;
      cnt_q <= '0;
    end else if (adv) begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  assign state = st_q;

  // R2
  sleep_from_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_SLEEP) |-> ($past(st_q) == ST_ENTER && $past(req)));

  // R3
  enter_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ENTER && !req) |=> (st_q == ST_NORMAL));

  // R6
  leave_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SLEEP && !req) |=> (st_q == ST_WAKE));

  // R10
  wake_no_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAKE) |=> (st_q == ST_WAKE || st_q == ST_NORMAL));
endmodule

// File: rtl/nap_cmd_gate.sv
`timescale 1ns/1ps
module nap_cmd_gate import nap_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  nap_state_e       state,
  input  logic [CMD_W-1:0] cmd_in,
  input  logic             oe_req,
  output logic [CMD_W-1:0] cmd_out,
  output logic             oe_gated,
  output logic             in_dis,
  output logic             viol
);
  logic asleep;
  logic allowed;
  logic blocked;
  logic viol_q;

  assign asleep  = (state == ST_SLEEP);
  assign allowed = (cmd_in == CMD_DESEL) || (cmd_in == CMD_READ);
  assign blocked = (state == ST_WAKE) && !allowed;

  always_comb begin
    if (asleep || blocked) cmd_out = CMD_DESEL;
    else                   cmd_out = cmd_in;
  end

  assign oe_gated = oe_req && !asleep;
  assign in_dis   = asleep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= blocked;
  end

  assign viol = viol_q;

  // R8
  viol_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> ($past(state) == ST_WAKE &&
              ($past(cmd_in) == CMD_WRITE || $past(cmd_in) == CMD_CONT)));

  // R7
  wake_read_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAKE && cmd_in == CMD_READ) |-> (cmd_out == CMD_READ));
endmodule

// File: rtl/nap_ctrl.sv
`timescale 1ns/1ps
module nap_ctrl import nap_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int ENTRY_CYC   = 2,
  parameter int WAKE_CYC    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_pin,
  input  logic [CMD_W-1:0] cmd_in,
  input  logic             oe_req,
  output logic [CMD_W-1:0] cmd_out,
  output logic             oe_gated,
  output logic             in_dis,
  output logic             rec_viol,
  output logic [1:0]       state_o
);
  logic       rst_sync_n;
  logic       req_s;
  nap_state_e st;

  nap_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sync_n)
  );

  nap_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (sleep_pin),
    .q     (req_s)
  );

  nap_fsm #(.ENTRY_CYC(ENTRY_CYC), .WAKE_CYC(WAKE_CYC)) u_fsm (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .req   (req_s),
    .state (st)
  );

  nap_cmd_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .state    (st),
    .cmd_in   (cmd_in),
    .oe_req   (oe_req),
    .cmd_out  (cmd_out),
    .oe_gated (oe_gated),
    .in_dis   (in_dis),
    .viol     (rec_viol)
  );

  assign state_o = st;

  // R4
  sleep_desel_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st == ST_SLEEP) |-> (cmd_out == CMD_DESEL && !oe_gated && in_dis));

  // R9
  normal_pass_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st == ST_NORMAL || st == ST_ENTER) |-> (cmd_out == cmd_in && !in_dis));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sync_n |=> (!rec_viol || !rst_sync_n));
endmodule

// File: tb/nap_ctrl_test.sv
`timescale 1ns/1ps
module nap_ctrl_test;
  import nap_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pin;
  logic [1:0] cmd;
  logic       oe;
  logic [1:0] cmd_out;
  logic       oe_gated, in_dis, rec_viol;
  logic [1:0] state_o;

  int  errs   = 0;
  int  checks = 0;
  bit  run    = 1'b0;

  always #4 clk = ~clk;

  nap_ctrl uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_pin (pin),
    .cmd_in    (cmd),
    .oe_req    (oe),
    .cmd_out   (cmd_out),
    .oe_gated  (oe_gated),
    .in_dis    (in_dis),
    .rec_viol  (rec_viol),
    .state_o   (state_o)
  );

  // Reference model derived from the requirements
  logic       m_s1, m_s2, m_viol;
  logic [1:0] m_st;
  int         m_dwell;

  function automatic bit is_blocked(logic [1:0] st, logic [1:0] c);
    return (st == 2'd3) && (c == 2'd2 || c == 2'd3);
  endfunction

  function automatic logic [1:0] exp_cmd(logic [1:0] st, logic [1:0] c);
    if (st == 2'd2 || is_blocked(st, c)) return 2'd0;
    return c;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 1'b0; m_s2 <= 1'b0; m_viol <= 1'b0; m_st <= 2'd0; m_dwell <= 0;
    end else begin
      m_s1   <= pin;
      m_s2   <= m_s1;
      m_viol <= is_blocked(m_st, cmd);
      case (m_st)
        2'd0: if (m_s2) begin m_st <= 2'd1; m_dwell <= 1; end
        2'd1: if (!m_s2) m_st <= 2'd0;
              else if (m_dwell >= 1) m_st <= 2'd2;
              else m_dwell <= m_dwell + 1;
        2'd2: if (!m_s2) begin m_st <= 2'd3; m_dwell <= 1; end
        default: if (m_dwell >= 1) m_st <= 2'd0;
                 else m_dwell <= m_dwell + 1;
      endcase
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
  endtask

  // Every-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (run) begin
      #2;
      chk("R2 R3 R6 R10 state", state_o, m_st);
      chk("R4 R7 R8 R9 cmd_out", cmd_out, exp_cmd(m_st, cmd));
      chk("R5 oe_gated", oe_gated, (oe && m_st != 2'd2));
      chk("R4 in_dis", in_dis, (m_st == 2'd2));
      chk("R8 rec_viol", rec_viol, m_viol);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errs++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    rst_n = 1'b0; pin = 1'b0; cmd = 2'd0; oe = 1'b1;
    cyc(3); #2;
    chk("R1 state in reset", state_o, 0);
    chk("R1 viol in reset", rec_viol, 0);
    chk("R1 in_dis in reset", in_dis, 0);
    @(negedge clk); rst_n = 1'b1;
    cyc(4);
    run = 1'b1;
    #2;
    chk("R1 state after reset", state_o, 0);

    // R2 entry timing
    @(negedge clk); pin = 1'b1; cmd = CMD_WRITE;
    cyc(3); #2; chk("R2 entering", state_o, 1);
    chk("R9 entering pass", cmd_out, 2);
    cyc(1); #2; chk("R2 sleep", state_o, 2);
    // R4 R5 in sleep
    chk("R4 desel in sleep", cmd_out, 0);
    chk("R5 oe gated in sleep", oe_gated, 0);
    chk("R4 in_dis in sleep", in_dis, 1);
    @(negedge clk); cmd = CMD_READ; #2;
    chk("R4 read blocked in sleep", cmd_out, 0);

    // R6 R8 wake with a write
    @(negedge clk); pin = 1'b0; cmd = CMD_WRITE;
    cyc(3); #2;
    chk("R6 waking", state_o, 3);
    chk("R8 write blocked", cmd_out, 0);
    chk("R5 oe in waking", oe_gated, 1);
    cyc(1); #2;
    chk("R6 normal", state_o, 0);
    chk("R8 viol pulse", rec_viol, 1);
    chk("R9 write in normal", cmd_out, 2);
    cyc(1); #2;
    chk("R8 viol single", rec_viol, 0);

    // R3 abort by one-cycle pulse
    @(negedge clk); pin = 1'b1;
    @(negedge clk); pin = 1'b0;
    cyc(2); #2; chk("R3 entering", state_o, 1);
    cyc(1); #2; chk("R3 back to normal", state_o, 0);
    cyc(1); #2; chk("R3 no sleep", state_o, 0);

    // R7 read passes in recovery
    @(negedge clk); pin = 1'b1;
    cyc(5);
    pin = 1'b0; cmd = CMD_READ;
    cyc(3); #2;
    chk("R7 waking", state_o, 3);
    chk("R7 read pass", cmd_out, 1);
    cyc(1); #2; chk("R7 no viol", rec_viol, 0);

    // R10 request returns during wake
    @(negedge clk); pin = 1'b1; cmd = CMD_DESEL;
    cyc(5);
    pin = 1'b0;
    @(negedge clk); pin = 1'b1;
    cyc(2); #2; chk("R10 waking", state_o, 3);
    chk("R7 desel pass", cmd_out, 0);
    cyc(1); #2; chk("R10 normal first", state_o, 0);
    cyc(1); #2; chk("R10 re-enter", state_o, 1);
    cyc(1); #2; chk("R10 sleep again", state_o, 2);

    // Constrained random phase
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (($urandom % 10) == 0) pin = ~pin;
      cmd = 2'($urandom % 4);
      oe  = 1'($urandom % 2);
    end
    @(negedge clk); pin = 1'b0;
    cyc(6);
    run = 1'b0;
    summary();
    $finish;
  end
endmodule